// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier with Multiplier-Quotient Register

This block multiplies two unsigned operands over several clock cycles. A one-cycle `start` pulse captures the multiplicand into an operand register and the multiplier into a shift register that also receives the low product bits (the multiplier-quotient register). The same edge clears the high-word accumulator. After that, a fixed number of step cycles follow. Each step recodes the two lowest remaining multiplier bits into a radix-4 Booth digit (0, ±M or ±2M) and adds that multiple to the accumulator. It then shifts the accumulator and the register right by two, so that finished low product bits move into the top of the register.

After the last step, one read cycle presents the high product word and copies the register out as the low product word. In the same cycle the block raises `done`, which also tells the surrounding pipeline that it may fetch its next instruction. The step cycles never raise it. The read cycle also applies the unsigned correction: when the multiplier's top bit is set, the multiplicand is added into the high word. When the captured multiplicand is zero, the step cycles are skipped. A single fixup cycle forces both product words to zero, and the read cycle follows at once.

Top module: `imul_booth_r4`

## Requirements
- R1: While reset is active and after it is released, `busy` and `done` are 0 until a start is accepted.
- R2: A `start` seen while `busy` is 0 is accepted at that clock edge. `busy` is 1 from the next cycle through the `done` cycle, and 0 in the cycle after `done`.
- R3: A `start` pulse while `busy` is 1 has no effect. This holds in the `done` cycle too: the running product, its timing and the return to idle are unchanged.
- R4: With a nonzero multiplicand, `done` is 1 exactly 17 cycles after the accepting edge (W/2 = 16 step cycles and then one read cycle), and never earlier.
- R5: In the `done` cycle, `{prod_hi, prod_lo}` equals the 64-bit unsigned product of the captured operands. `prod_hi` carries bits 63..32 and `prod_lo` carries bits 31..0.
- R6: With a zero multiplicand, `done` is 1 exactly 2 cycles after the accepting edge (one fixup cycle and then the read cycle), and both product words are 0.
- R7: `done` is a single-cycle pulse per accepted start.
- R8: Multipliers with the top bit set (including all ones) give the correct unsigned product. They are not treated as negative.
- R9: Operands are sampled only at the accepting edge. Changes to `mcand` or `mplier` afterwards do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, accepted only when idle |
| mcand | input | 32 | Multiplicand (unsigned) |
| mplier | input | 32 | Multiplier (unsigned) |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse; product valid in this cycle |
| prod_hi | output | 32 | Product bits 63..32, valid while done is high |
| prod_lo | output | 32 | Product bits 31..0, valid while done is high |

## Verification
Small operands check the basic step and shift path. Operands with the top multiplier bit set, up to all ones in both, show whether the unsigned correction is applied, since a signed-only Booth array gets those wrong. A zero multiplicand takes the short path, while a zero multiplier must still run all 16 steps; the two tell the early exit apart from ordinary zero accumulation. Runs that change the operands mid-computation, pulse `start` while busy, or hold `start` high throughout show whether operand capture and the ignore rule are sound. A long series of random operands covers the Booth digit mix.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIX  = 2'd2,
        ST_READ = 2'd3
    } imul_state_e;

    // One radix-4 Booth digit: magnitude one or two, optionally negated.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

endpackage

// File: rtl/imul_booth_recode.sv
module imul_booth_recode
    import imul_pkg::*;
(
    input  logic [2:0]  grp,   // {y(i+1), y(i), y(i-1)}
    output booth_dig_t  dig
);
    always_comb begin
        dig = '0;
        case (grp)
            3'b001, 3'b010: dig.one = 1'b1;
            3'b011:         dig.two = 1'b1;
            3'b100:         begin dig.two = 1'b1; dig.neg = 1'b1; end
            3'b101, 3'b110: begin dig.one = 1'b1; dig.neg = 1'b1; end
            default:        dig = '0;
        endcase
    end
endmodule

// File: rtl/imul_pp_sel.sv
module imul_pp_sel
    import imul_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = W + 3
) (
    input  logic [W-1:0]  mcand,
    input  booth_dig_t    dig,
    output logic [AW-1:0] pp
);
    logic [AW-1:0] mag;

    always_comb begin
        if (dig.two)
            mag = {{(AW-W-1){1'b0}}, mcand, 1'b0};
        else if (dig.one)
            mag = {{(AW-W){1'b0}}, mcand};
        else
            mag = '0;
        pp = dig.neg ? (~mag + AW'(1)) : mag;
    end
endmodule

// File: rtl/imul_acc_step.sv
module imul_acc_step #(
    parameter int W  = 32,
    parameter int AW = W + 3
) (
    input  logic [AW-1:0] hi,
    input  logic [W-1:0]  mq,
    input  logic [AW-1:0] pp,
    output logic [AW-1:0] hi_nx,
    output logic [W-1:0]  mq_nx
);
    logic [AW-1:0] sum;

    always_comb begin
        sum   = hi + pp;
        hi_nx = {{2{sum[AW-1]}}, sum[AW-1:2]};
        mq_nx = {sum[1:0], mq[W-1:2]};
    end
endmodule

// File: rtl/imul_booth_r4.sv
module imul_booth_r4
    import imul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    localparam int STEPS = W / 2;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int AW    = W + 3;

    typedef struct packed {
        imul_state_e    st;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   left;
        logic [AW-1:0]  hi;
        logic [W-1:0]   mq;
        logic           prev;
        logic           msb;
    } imul_regs_t;

    imul_regs_t r_d, r_q;

    booth_dig_t     dig;
    logic [AW-1:0]  pp;
    logic [AW-1:0]  hi_nx;
    logic [W-1:0]   mq_nx;

    imul_booth_recode u_recode (
        .grp ({r_q.mq[1:0], r_q.prev}),
        .dig (dig)
    );

    imul_pp_sel #(.W(W), .AW(AW)) u_pp (
        .mcand (r_q.left),
        .dig   (dig),
        .pp    (pp)
    );

    imul_acc_step #(.W(W), .AW(AW)) u_step (
        .hi    (r_q.hi),
        .mq    (r_q.mq),
        .pp    (pp),
        .hi_nx (hi_nx),
        .mq_nx (mq_nx)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.left = mcand;
                    r_d.mq   = mplier;
                    r_d.hi   = '0;
                    r_d.prev = 1'b0;
                    r_d.msb  = mplier[W-1];
                    r_d.cnt  = '0;
                    r_d.st   = (mcand == '0) ? ST_FIX : ST_STEP;
                end
            end
            ST_STEP: begin
                r_d.hi   = hi_nx;
                r_d.mq   = mq_nx;
                r_d.prev = r_q.mq[1];
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(STEPS - 1))
                    r_d.st = ST_READ;
            end
            ST_FIX: begin
                r_d.hi  = '0;
                r_d.mq  = '0;
                r_d.msb = 1'b0;
                r_d.st  = ST_READ;
            end
            ST_READ: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // The signed Booth result is off by mcand*2^W when the multiplier's top
    // bit is set; add it back in the read cycle.
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = (r_q.st == ST_READ);
    assign prod_hi = r_q.hi[W-1:0] + (r_q.msb ? r_q.left : '0);
    assign prod_lo = r_q.mq;

endmodule

// File: rtl/imul_booth_r4_chk.sv
module imul_booth_r4_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] mcand,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo
);
    localparam int KW = $clog2(W) + 2;

    logic [KW-1:0] cyc;
    logic          zr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            zr  <= 1'b0;
        end else if (start && !busy) begin
            cyc <= KW'(1);
            zr  <= (mcand == '0);
        end else if (busy) begin
            cyc <= cyc + KW'(1);
        end
    end

    // R1
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    nonzero_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zr) |-> (cyc == KW'(W/2 + 1)));

    // R6
    zero_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zr) |-> (cyc == KW'(2)));

    // R6
    zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zr) |-> (prod_hi == '0 && prod_lo == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind imul_booth_r4 imul_booth_r4_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/imul_booth_r4_tb.sv
module imul_booth_r4_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic         busy, done;
    logic [W-1:0] prod_hi, prod_lo;

    imul_booth_r4 #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: remaining cycles until idle, and the product.
    bit          m_busy = 0;
    int          m_rem  = 0;
    bit          m_zero = 0;
    bit          m_msb  = 0;
    logic [63:0] m_prod = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0;
            m_rem  = 0;
        end else if (m_busy) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) m_busy = 0;
        end else if (start) begin
            m_busy = 1;
            m_zero = (mcand == 0);
            m_msb  = mplier[W-1];
            m_rem  = m_zero ? 2 : W/2 + 1;
            m_prod = {32'b0, mcand} * {32'b0, mplier};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_done;
            exp_done = m_busy && (m_rem == 1);
            chk(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
            chk(done == exp_done, m_zero ? "R6 R7 done timing" : "R4 R7 done timing",
                64'(done), 64'(exp_done));
            if (exp_done)
                chk({prod_hi, prod_lo} == m_prod,
                    m_zero ? "R6 product" : (m_msb ? "R8 product" : "R5 product"),
                    {prod_hi, prod_lo}, m_prod);
        end
    end

    // mode 0: plain, 1: extra start pulse mid-run, 2: start held high throughout
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input int mode, input string tag);
        logic [63:0] exp, res;
        bit got;
        exp = {32'b0, a} * {32'b0, b};
        got = 0;
        res = '0;
        @(negedge clk);
        start = 1; mcand = a; mplier = b;
        @(negedge clk);
        start = (mode == 2);
        mcand = ~a; mplier = b ^ 32'h5A5A_C3C3;   // R9: operands move after capture
        for (int i = 0; i < 40; i++) begin
            if (done) begin got = 1; res = {prod_hi, prod_lo}; end
            if (!busy) break;
            start = (mode == 2) || (mode == 1 && (i == 3 || done));
            if (start) begin mcand = 32'h0000_1234; mplier = 32'h8000_0001; end
            @(negedge clk);
        end
        start = 0;
        chk(got, {tag, " done seen"}, 64'(got), 64'd1);
        chk(res == exp, tag, res, exp);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 150000) begin
                n_err++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
                $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 in reset", {busy, done}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 after reset", {busy, done}, 64'd0);

        run_mul(32'd3, 32'd5, 0, "R5 small");
        run_mul(32'd7, 32'd0, 0, "R5 zero multiplier");
        run_mul(32'hFFFF_FFFF, 32'd1, 0, "R5 max multiplicand");
        run_mul(32'd0, 32'hFFFF_FFFF, 0, "R6 zero multiplicand");
        run_mul(32'd0, 32'd0, 0, "R6 both zero");
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R8 all ones");
        run_mul(32'd1, 32'h8000_0000, 0, "R8 top bit only");
        run_mul(32'h1357_9BDF, 32'hAAAA_AAAA, 0, "R8 alternating");
        run_mul(32'hDEAD_BEEF, 32'h1234_5678, 1, "R3 start while busy");
        run_mul(32'd0, 32'h0000_0042, 1, "R3 start while busy zero path");
        run_mul(32'h0BAD_F00D, 32'hC0DE_0001, 2, "R3 start held high");
        run_mul(32'h8765_4321, 32'h0F0F_0F0F, 0, "R9 operand change");

        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (k % 10 == 0) ra = 0;
            run_mul(ra, rb, k % 3, rb[W-1] ? "R8 random" : "R5 random");
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule